// File: doc/BRIEF.md
# Wake-Up Source Latch Register

This block watches a small set of local wake inputs for a low-power controller. The inputs are grouped in pairs. Each pair has a 2-bit sense field that picks how its inputs are watched: not at all, for a high level, for a low level, or for any change of level. While the controller is in one of its low-power modes (sleep or stop), an enabled input that meets its sense condition sets its own sticky wake flag and raises a wake request. The wake request stays up until the power manager acknowledges the mode change.

The status word has two meanings. After a wake-up it names the inputs that caused it. After the first read strobe, it shows the live, synchronized input levels. A watchdog timeout in stop mode that arrives before that first read clears the latched source bits. The raw inputs pass through a two-stage synchronizer before any detection.

Top module: `wake_src_reg`

## Requirements
- R1: After reset, the sense fields read back as 0, wake_req is low, and status shows the live synchronized input levels.
- R2: A write with cfg_wr stores cfg_wdata. cfg_rdata returns it from the next cycle on and holds it while cfg_wr is low. Bits [1:0] control inputs 0 and 1. Bits [3:2] control inputs 2 and 3.
- R3: Sense code 00 disables both inputs of the pair. They never set a flag or wake_req.
- R4: Sense code 01 sets the flag of an input whose synchronized level is high while low_power is high.
- R5: Sense code 10 sets the flag of an input whose synchronized level is low while low_power is high.
- R6: Sense code 11 sets the flag of an input whose synchronized level changes, in either direction, while low_power is high.
- R7: When low_power is low, no input sets a flag or raises wake_req.
- R8: Once a wake-up has been latched, status shows the wake flags (1 = that input caused a wake) until the first rd_strobe, whatever the inputs do afterwards.
- R9: A rd_strobe clears the latched source. From then on status shows the live input levels (1 = high), which lag lx_raw by two clock cycles.
- R10: wake_req rises only when a wake is detected during low_power. It then stays high until mode_ack, which clears it in the next cycle.
- R11: A wdog_tmo pulse while stop_mode is high and a source is latched clears the wake flags, so status reads all zero until rd_strobe. With stop_mode low, the pulse leaves the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lx_raw | input | 4 | Raw wake inputs |
| low_power | input | 1 | High while in sleep or stop mode |
| stop_mode | input | 1 | High when the low-power mode is stop |
| wdog_tmo | input | 1 | Watchdog timeout pulse |
| mode_ack | input | 1 | Power manager acknowledge; clears wake_req |
| cfg_wr | input | 1 | Write strobe for the sense fields |
| cfg_wdata | input | 4 | Sense field write data |
| cfg_rdata | output | 4 | Sense field readback |
| rd_strobe | input | 1 | Status read strobe |
| status | output | 4 | Latched wake source or live levels |
| wake_req | output | 1 | Wake request to the power manager |

## Verification
The bench builds the block with its default parameters: four inputs in two pairs and two synchronizer stages. Two pairs are enough to give the two pairs different sense codes at the same time, so one vector can show a high-level pair and a low-level pair each waking from its own input. The fixed two-stage latency lets the bench expect the live status exactly two cycles after an input change.

// File: rtl/wake_src_pkg.sv
package wake_src_pkg;
  typedef enum logic [1:0] {
    SENSE_OFF  = 2'b00,
    SENSE_HIGH = 2'b01,
    SENSE_LOW  = 2'b10,
    SENSE_BOTH = 2'b11
  } sense_e;

  localparam int SENSE_W = 2;
endpackage

// File: rtl/wake_sync.sv
module wake_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] q_out
);
  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] stg_d [STAGES];

  always_comb begin
    stg_d[0] = d_in;
    for (int i = 1; i < STAGES; i++) stg_d[i] = stg_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= stg_d[i];
    end
  end

  assign q_out = stg_q[STAGES-1];
endmodule

// File: rtl/wake_detect.sv
module wake_detect
  import wake_src_pkg::*;
#(
  parameter  int N_IN   = 4,
  parameter  int GRP_SZ = 2,
  localparam int N_GRP  = N_IN / GRP_SZ,
  localparam int CFG_W  = N_GRP * SENSE_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [CFG_W-1:0] cfg,
  input  logic [N_IN-1:0] lvl,
  output logic [N_IN-1:0] hit
);
  logic [N_IN-1:0] prev_q;
  logic [N_IN-1:0] prev_d;

  assign prev_d = lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_d;
  end

  for (genvar g = 0; g < N_IN; g++) begin : g_in
    localparam int GRP = g / GRP_SZ;
    sense_e mode;
    assign mode = sense_e'(cfg[GRP*SENSE_W +: SENSE_W]);
    always_comb begin
      case (mode)
        SENSE_HIGH: hit[g] = lvl[g];
        SENSE_LOW:  hit[g] = ~lvl[g];
        SENSE_BOTH: hit[g] = lvl[g] ^ prev_q[g];
        default:    hit[g] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/wake_latch.sv
module wake_latch #(
  parameter int N_IN = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            low_power,
  input  logic            stop_mode,
  input  logic            wdog_tmo,
  input  logic            rd_strobe,
  input  logic            mode_ack,
  input  logic [N_IN-1:0] hit,
  output logic [N_IN-1:0] flags,
  output logic            src_valid,
  output logic            wake_req
);
  logic [N_IN-1:0] flags_q, flags_d, hit_lp;
  logic            valid_q, valid_d, req_q, req_d, any_hit;

  assign hit_lp  = low_power ? hit : '0;
  assign any_hit = |hit_lp;

  always_comb begin
    flags_d = flags_q;
    valid_d = valid_q;
    req_d   = req_q;
    if (rd_strobe && valid_q) begin
      flags_d = '0;
      valid_d = 1'b0;
    end
    if (wdog_tmo && stop_mode && valid_q) flags_d = '0;
    if (mode_ack) req_d = 1'b0;
    flags_d = flags_d | hit_lp;
    if (any_hit) begin
      valid_d = 1'b1;
      req_d   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      valid_q <= 1'b0;
      req_q   <= 1'b0;
    end else begin
      flags_q <= flags_d;
      valid_q <= valid_d;
      req_q   <= req_d;
    end
  end

  assign flags     = flags_q;
  assign src_valid = valid_q;
  assign wake_req  = req_q;

  // R10
  req_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_req) |-> $past(low_power));
  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_req && !mode_ack) |=> wake_req);
  // R9
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !any_hit) |=> !src_valid);
  // R11
  wdog_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wdog_tmo && stop_mode && src_valid && !any_hit) |=> (flags == '0));
endmodule

// File: rtl/wake_src_reg.sv
module wake_src_reg
  import wake_src_pkg::*;
#(
  parameter  int N_IN     = 4,
  parameter  int GRP_SZ   = 2,
  parameter  int SYNC_STG = 2,
  localparam int CFG_W    = (N_IN / GRP_SZ) * SENSE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IN-1:0]  lx_raw,
  input  logic             low_power,
  input  logic             stop_mode,
  input  logic             wdog_tmo,
  input  logic             mode_ack,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  input  logic             rd_strobe,
  output logic [N_IN-1:0]  status,
  output logic             wake_req
);
  logic [CFG_W-1:0] cfg_q, cfg_d;
  logic [N_IN-1:0]  lvl_s, hit, flags;
  logic             src_valid;

  always_comb begin
    cfg_d = cfg_q;
    if (cfg_wr) cfg_d = cfg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  wake_sync #(.W(N_IN), .STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_in(lx_raw), .q_out(lvl_s));

  wake_detect #(.N_IN(N_IN), .GRP_SZ(GRP_SZ)) u_det (
    .clk(clk), .rst_n(rst_n), .cfg(cfg_q), .lvl(lvl_s), .hit(hit));

  wake_latch #(.N_IN(N_IN)) u_latch (
    .clk(clk), .rst_n(rst_n), .low_power(low_power), .stop_mode(stop_mode),
    .wdog_tmo(wdog_tmo), .rd_strobe(rd_strobe), .mode_ack(mode_ack),
    .hit(hit), .flags(flags), .src_valid(src_valid), .wake_req(wake_req));

  assign cfg_rdata = cfg_q;
  assign status    = src_valid ? flags : lvl_s;

  // R2
  cfg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (cfg_rdata == $past(cfg_wdata)));
  // R2
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> $stable(cfg_rdata));
endmodule

// File: tb/wake_src_reg_bench.sv
module wake_src_reg_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] lx_raw;
  logic       low_power, stop_mode, wdog_tmo, mode_ack, cfg_wr, rd_strobe;
  logic [3:0] cfg_wdata, cfg_rdata, status;
  logic       wake_req;
  int         errors = 0;
  int         checks = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  wake_src_reg u_wake_src_reg (
    .clk(clk), .rst_n(rst_n), .lx_raw(lx_raw), .low_power(low_power),
    .stop_mode(stop_mode), .wdog_tmo(wdog_tmo), .mode_ack(mode_ack),
    .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .rd_strobe(rd_strobe), .status(status), .wake_req(wake_req));

  // {cfg, lx before, lx during low power, expected status, expected req}
  localparam int NV = 7;
  localparam logic [16:0] VEC [NV] = '{
    {4'b0000, 4'b0000, 4'b1111, 4'b1111, 1'b0},  // R3 disabled
    {4'b0101, 4'b0000, 4'b0100, 4'b0100, 1'b1},  // R4 high level
    {4'b1010, 4'b1111, 4'b1101, 4'b0010, 1'b1},  // R5 low level
    {4'b1111, 4'b0000, 4'b1001, 4'b1001, 1'b1},  // R6 rising
    {4'b1111, 4'b1111, 4'b0111, 4'b1000, 1'b1},  // R6 falling
    {4'b0110, 4'b0011, 4'b0110, 4'b0101, 1'b1},  // R4 R5 mixed pairs
    {4'b0001, 4'b0000, 4'b1100, 4'b1100, 1'b0}   // R3 pair disabled
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string rq, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic wr_cfg(input logic [3:0] v);
    cfg_wr = 1'b1; cfg_wdata = v; tick(1); cfg_wr = 1'b0;
  endtask

  task automatic pulse_rd();
    rd_strobe = 1'b1; tick(1); rd_strobe = 1'b0;
  endtask

  task automatic pulse_ack();
    mode_ack = 1'b1; tick(1); mode_ack = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; lx_raw = 4'b1010; low_power = 1'b0; stop_mode = 1'b0;
    wdog_tmo = 1'b0; mode_ack = 1'b0; cfg_wr = 1'b0; cfg_wdata = '0; rd_strobe = 1'b0;
    tick(3); rst_n = 1'b1; tick(3);
    chk("R1 cfg", 8'(cfg_rdata), 8'h0);
    chk("R1 req", 8'(wake_req), 8'h0);
    chk("R1 status live", 8'(status), 8'hA);

    wr_cfg(4'h9);
    chk("R2 readback", 8'(cfg_rdata), 8'h9);
    cfg_wdata = 4'h6; tick(2);
    chk("R2 hold", 8'(cfg_rdata), 8'h9);

    // R7: matching levels outside low power do nothing
    wr_cfg(4'b0101); lx_raw = 4'b1111; tick(5);
    chk("R7 req", 8'(wake_req), 8'h0);
    chk("R7 status live", 8'(status), 8'hF);

    for (int v = 0; v < NV; v++) begin
      logic [3:0] c, bf, du, es;
      logic       er;
      {c, bf, du, es, er} = VEC[v];
      wr_cfg(c);
      lx_raw = bf; tick(4);
      low_power = 1'b1; lx_raw = du; tick(5);
      chk($sformatf("R4/R5/R6 vec%0d status", v), 8'(status), 8'(es));
      chk($sformatf("R10 vec%0d req", v), 8'(wake_req), 8'(er));
      low_power = 1'b0; tick(2);
      chk($sformatf("R10 vec%0d req held", v), 8'(wake_req), 8'(er));
      pulse_ack();
      chk($sformatf("R10 vec%0d req after ack", v), 8'(wake_req), 8'h0);
      pulse_rd(); tick(1);
      chk($sformatf("R9 vec%0d live after read", v), 8'(status), 8'(du));
    end

    // R8 + R11: sleep (stop_mode low) keeps the source through a watchdog pulse
    wr_cfg(4'b0101); lx_raw = 4'b0000; tick(4);
    low_power = 1'b1; stop_mode = 1'b0; lx_raw = 4'b0001; tick(5);
    low_power = 1'b0; lx_raw = 4'b0000; tick(4);
    chk("R8 latched over live", 8'(status), 8'h1);
    wdog_tmo = 1'b1; tick(1); wdog_tmo = 1'b0; tick(1);
    chk("R11 sleep keeps source", 8'(status), 8'h1);
    pulse_ack(); pulse_rd(); tick(1);
    chk("R9 live after read", 8'(status), 8'h0);

    // R11: stop mode watchdog before the read clears the source
    low_power = 1'b1; stop_mode = 1'b1; lx_raw = 4'b0001; tick(5);
    low_power = 1'b0; tick(1);
    chk("R8 stop source", 8'(status), 8'h1);
    wdog_tmo = 1'b1; tick(1); wdog_tmo = 1'b0; tick(1);
    chk("R11 stop clears", 8'(status), 8'h0);
    pulse_rd(); tick(1);
    chk("R9 live after clear", 8'(status), 8'h1);
    wdog_tmo = 1'b1; tick(1); wdog_tmo = 1'b0; tick(1);
    chk("R11 no effect after read", 8'(status), 8'h1);
    pulse_ack(); stop_mode = 1'b0;

    // R9: live status lags input by two cycles
    lx_raw = 4'b0110; tick(1);
    chk("R9 lag one cycle", 8'(status), 8'h1);
    tick(1);
    chk("R9 lag two cycles", 8'(status), 8'h6);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule